// File: doc/BRIEF.md
# Sixteen-Bit Timer with Dual Compare, Capture and Phase-Correct PWM

This block is a 16-bit counter that advances once for each strobe from an external prescaler. In its normal mode it counts up and wraps from all ones to zero. Two compare channels watch the count. Each channel raises its own flag when the count lands on its value, and each drives an output pin. A capture channel stores the count when a chosen edge arrives on the capture pin. A wrap of the counter raises an overflow flag.

In the alternative mode the counter runs from zero up to a top value and then back down to zero. The top value gives a resolution of 8, 9 or 10 bits. The two compare channels then produce phase-correct, non-inverted PWM on their pins. Compare values written in this mode take effect only when the counter reaches the top. Software reaches every register through an 8-bit register port, and the 16-bit registers pass through a shared temporary byte. Four interrupt lines are formed from the flags and a mask.

Top module: `tmr16_unit`

## Requirements
- R1: After reset the count, all flags, the mask, both compare values, both output pins, the interrupt lines and the read data are zero, and the block is in normal mode.
- R2: In normal mode each cycle with `cnt_en` high adds one to the count, and a cycle with `cnt_en` low leaves it unchanged. The step from 0xFFFF to 0x0000 sets the overflow flag (flag bit 0).
- R3: A strobe that brings the count equal to the active value of compare channel A sets flag bit 1, and one that does so for channel B sets flag bit 2. In normal mode the pin of that channel toggles in the same cycle.
- R4: The capture pin passes through a two-flop synchronizer. When the edge selected by control register B bit 0 arrives (1 = rising, 0 = falling), the current count is copied into the capture register and flag bit 3 is set. An edge of the other polarity changes neither.
- R5: Register map: 0 control A, 1 control B, 2 flags, 3 mask, 4/5 count low/high, 6/7 compare A low/high, 8/9 compare B low/high, 10/11 capture low/high (read-only). A write to an odd address from 5 to 11 loads the temporary byte, and a write to a low address stores {temporary, data}. A read of a low address returns the low byte and loads the temporary byte with that register's high byte, and a read of a high address returns the temporary byte. Read data is registered and appears one cycle after `bus_rd`.
- R6: Writing 1 to a bit of the flag register clears that flag, and writing 0 leaves it alone. An event in the same cycle as the clear wins.
- R7: Each interrupt line `irq[i]` equals flag bit i AND mask bit i, one cycle after the flag and the mask.
- R8: Control register A bits [1:0] = 1, 2 or 3 select PWM mode with top 0x00FF, 0x01FF or 0x03FF. The count rises to the top, falls to zero, then rises again. The step that reaches zero on the way down sets the overflow flag.
- R9: In PWM mode a compare match on an upward step clears the channel pin, and a match on a downward step sets it.
- R10: In PWM mode compare writes go to a buffer that reads back at once. The active compare value takes the buffer on the step that reaches the top, and matches on that step still use the old active value. In normal mode a write updates both the buffer and the active value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count strobe from the prescaler |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cap_in | input | 1 | Asynchronous capture pin |
| cmp_out_a | output | 1 | Compare channel A pin |
| cmp_out_b | output | 1 | Compare channel B pin |
| irq | output | 4 | Interrupt lines: overflow, compare A, compare B, capture |

## Verification
A counter that has slipped by even one step shows up at the next two-byte read of the count. Within one compare period it also moves the edges of both pins and the cycle in which the compare flags rise. A wrong direction bit in PWM mode reverses the slope at once, and so the next match drives the pin to the opposite level. A stale active compare value shows only after the following top. A temporary byte latched from the wrong register, or at the wrong moment, corrupts the high half of the very next read or write.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int CNT_W  = 16;
  localparam int BUS_W  = 8;
  localparam int ADDR_W = 4;
  localparam int NFLAG  = 4;

  localparam logic [ADDR_W-1:0] A_CTLA  = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTLB  = 4'd1;
  localparam logic [ADDR_W-1:0] A_FLAG  = 4'd2;
  localparam logic [ADDR_W-1:0] A_MASK  = 4'd3;
  localparam logic [ADDR_W-1:0] A_CNT_L = 4'd4;
  localparam logic [ADDR_W-1:0] A_CPA_L = 4'd6;
  localparam logic [ADDR_W-1:0] A_CAP_L = 4'd10;
  localparam logic [ADDR_W-1:0] A_LAST  = 4'd11;

  localparam int F_OVF = 0;
  localparam int F_CAP = 3;

  // top of the up-down slope for a resolution code of 1, 2 or 3
  function automatic logic [CNT_W-1:0] pwm_top(input logic [1:0] res);
    return CNT_W'((32'd1 << (32'd7 + 32'(res))) - 32'd1);
  endfunction
endpackage

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic         pwm_on,
  input  logic [W-1:0] top,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt_q,
  output logic         adv,
  output logic [W-1:0] nxt,
  output logic         up_step,
  output logic         top_ld,
  output logic         ovf_evt
);
  logic dn_q, dn_nxt, top_hit, wrap;

  always_comb begin
    adv     = strobe & ~ld;
    nxt     = cnt_q + 1'b1;
    up_step = 1'b1;
    dn_nxt  = dn_q;
    top_hit = 1'b0;
    wrap    = 1'b0;
    if (!pwm_on) begin
      wrap   = &cnt_q;
      dn_nxt = 1'b0;
    end else if (!dn_q) begin
      if (cnt_q >= top) begin
        nxt     = cnt_q - 1'b1;
        up_step = 1'b0;
        dn_nxt  = 1'b1;
      end else begin
        top_hit = (nxt == top);
      end
    end else begin
      if (cnt_q == '0) begin
        dn_nxt = 1'b0;
      end else begin
        nxt     = cnt_q - 1'b1;
        up_step = 1'b0;
        wrap    = (cnt_q == W'(1));
      end
    end
    top_ld  = adv & top_hit;
    ovf_evt = adv & wrap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else begin
      if (!pwm_on)  dn_q <= 1'b0;
      else if (adv) dn_q <= dn_nxt;
      if (ld)       cnt_q <= ld_val;
      else if (adv) cnt_q <= nxt;
    end
  end
endmodule

// File: rtl/tmr16_compare.sv
module tmr16_compare #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pwm_on,
  input  logic         wr,
  input  logic [W-1:0] wr_val,
  input  logic         adv,
  input  logic [W-1:0] nxt,
  input  logic         up_step,
  input  logic         top_ld,
  output logic [W-1:0] buf_q,
  output logic         hit,
  output logic         pin_q
);
  logic [W-1:0] act_q;

  assign hit = adv && (nxt == act_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      act_q <= '0;
      pin_q <= 1'b0;
    end else begin
      if (top_ld) act_q <= buf_q;
      if (wr) begin
        buf_q <= wr_val;
        if (!pwm_on) act_q <= wr_val;
      end
      if (hit) pin_q <= pwm_on ? ~up_step : ~pin_q;
    end
  end
endmodule

// File: rtl/tmr16_capture.sv
module tmr16_capture #(
  parameter int W    = 16,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pin,
  input  logic         rise_sel,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] cap_q,
  output logic         evt
);
  localparam int SH = SYNC + 1;
  logic [SH-1:0] sh_q;
  logic          cur, prev;

  assign cur  = sh_q[SYNC-1];
  assign prev = sh_q[SYNC];
  assign evt  = rise_sel ? (cur & ~prev) : (~cur & prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      cap_q <= '0;
    end else begin
      sh_q <= {sh_q[SH-2:0], pin};
      if (evt) cap_q <= cnt;
    end
  end
endmodule

// File: rtl/tmr16_unit.sv
module tmr16_unit
  import tmr16_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              cap_in,
  output logic              cmp_out_a,
  output logic              cmp_out_b,
  output logic [NFLAG-1:0]  irq
);
  localparam int NCMP = 2;
  localparam int HB   = CNT_W - BUS_W;

  logic [1:0]       ctla_q;
  logic             ctlb_q;
  logic [NFLAG-1:0] flag_q, mask_q, flag_clr, flag_set;
  logic [BUS_W-1:0] tmp_q;
  logic [CNT_W-1:0] wr16, cnt_q, nxt, top, cap_q;
  logic             pwm_on, cnt_ld, adv, up_step, top_ld, ovf_evt, cap_evt;
  logic             hi_wr, lo_rd;
  logic [CNT_W-1:0] cmp_buf [NCMP];
  logic [NCMP-1:0]  cmp_hit, cmp_pin;
  logic [CNT_W-1:0] lo_src;

  assign pwm_on = (ctla_q != 2'd0);
  assign top    = pwm_top(ctla_q);
  assign wr16   = {tmp_q[HB-1:0], bus_wdata};
  assign cnt_ld = bus_wr && (bus_addr == A_CNT_L);
  assign hi_wr  = bus_wr && bus_addr[0] && (bus_addr > A_CNT_L) && (bus_addr <= A_LAST);
  assign lo_rd  = bus_rd && !bus_addr[0] && (bus_addr >= A_CNT_L) && (bus_addr <= A_CAP_L);

  tmr16_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .strobe(cnt_en), .pwm_on(pwm_on), .top(top),
    .ld(cnt_ld), .ld_val(wr16), .cnt_q(cnt_q), .adv(adv), .nxt(nxt),
    .up_step(up_step), .top_ld(top_ld), .ovf_evt(ovf_evt)
  );

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(32'(A_CPA_L) + 2 * i);
    tmr16_compare #(.W(CNT_W)) u_cmp (
      .clk(clk), .rst(rst), .pwm_on(pwm_on),
      .wr(bus_wr && (bus_addr == LO)), .wr_val(wr16),
      .adv(adv), .nxt(nxt), .up_step(up_step), .top_ld(top_ld),
      .buf_q(cmp_buf[i]), .hit(cmp_hit[i]), .pin_q(cmp_pin[i])
    );
  end

  tmr16_capture #(.W(CNT_W), .SYNC(2)) u_cap (
    .clk(clk), .rst(rst), .pin(cap_in), .rise_sel(ctlb_q), .cnt(cnt_q),
    .cap_q(cap_q), .evt(cap_evt)
  );

  assign cmp_out_a = cmp_pin[0];
  assign cmp_out_b = cmp_pin[1];

  assign flag_set = {cap_evt, cmp_hit, ovf_evt};
  assign flag_clr = (bus_wr && bus_addr == A_FLAG) ? bus_wdata[NFLAG-1:0] : '0;

  always_comb begin
    case (bus_addr)
      A_CNT_L:     lo_src = cnt_q;
      A_CPA_L:     lo_src = cmp_buf[0];
      A_CPA_L + 2: lo_src = cmp_buf[1];
      default:     lo_src = cap_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctla_q    <= '0;
      ctlb_q    <= 1'b0;
      flag_q    <= '0;
      mask_q    <= '0;
      tmp_q     <= '0;
      bus_rdata <= '0;
      irq       <= '0;
    end else begin
      flag_q <= (flag_q & ~flag_clr) | flag_set;
      irq    <= flag_q & mask_q;
      if (bus_wr && bus_addr == A_CTLA) ctla_q <= bus_wdata[1:0];
      if (bus_wr && bus_addr == A_CTLB) ctlb_q <= bus_wdata[0];
      if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata[NFLAG-1:0];
      if (hi_wr)      tmp_q <= bus_wdata;
      else if (lo_rd) tmp_q <= lo_src[CNT_W-1:BUS_W];
      if (bus_rd) begin
        case (bus_addr)
          A_CTLA:  bus_rdata <= BUS_W'(ctla_q);
          A_CTLB:  bus_rdata <= BUS_W'(ctlb_q);
          A_FLAG:  bus_rdata <= BUS_W'(flag_q);
          A_MASK:  bus_rdata <= BUS_W'(mask_q);
          default: bus_rdata <= bus_addr[0] ? tmp_q : lo_src[BUS_W-1:0];
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk (
  input logic        clk,
  input logic        rst,
  input logic        cnt_en,
  input logic        cnt_ld,
  input logic [15:0] cnt_q,
  input logic        pwm_on,
  input logic [15:0] top,
  input logic        hit_a,
  input logic        pin_a,
  input logic        cap_evt,
  input logic [15:0] cap_q,
  input logic [3:0]  flag_q
);
  // R1: reset leaves the count and the flags cleared
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (cnt_q == 16'd0 && flag_q == 4'd0));

  // R2: no strobe and no load means the count holds
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !cnt_ld) |=> $stable(cnt_q));

  // R3: a normal-mode match flips channel A's pin
  assert_match_toggle_R3: assert property (@(posedge clk) disable iff (rst)
    (!pwm_on && hit_a) |=> (pin_a != $past(pin_a)));

  // R4: a capture event stores the count and raises the capture flag
  assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> (cap_q == $past(cnt_q) && flag_q[3]));

  // R8: a strobe at the top turns the count downward
  assert_top_turn_R8: assert property (@(posedge clk) disable iff (rst)
    (pwm_on && cnt_en && !cnt_ld && cnt_q == top) |=> (cnt_q == $past(top) - 16'd1));
endmodule

bind tmr16_unit tmr16_chk u_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .cnt_ld(cnt_ld), .cnt_q(cnt_q),
  .pwm_on(pwm_on), .top(top), .hit_a(cmp_hit[0]), .pin_a(cmp_out_a),
  .cap_evt(cap_evt), .cap_q(cap_q), .flag_q(flag_q)
);

// File: tb/test_tmr16_unit.sv
`timescale 1ns/1ps
module test_tmr16_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cap_in = 1'b0;
  logic       cmp_out_a, cmp_out_b;
  logic [3:0] irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // bench model of the architectural state
  logic [15:0] m_cnt = '0;
  logic        m_dn = 1'b0;
  logic [1:0]  m_mode = '0;
  logic [15:0] m_act [2] = '{16'd0, 16'd0};
  logic [15:0] m_buf [2] = '{16'd0, 16'd0};
  logic [1:0]  m_pin = '0;
  logic [3:0]  m_flag = '0;

  always #4 clk = ~clk;

  tmr16_unit i_tmr16_unit (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
    .cmp_out_a(cmp_out_a), .cmp_out_b(cmp_out_b), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] top_of(input logic [1:0] res);
    return 16'((32'd1 << (7 + res)) - 1);
  endfunction

  function automatic void model_step();
    logic [15:0] nx;
    logic up, tl, wrap, dn2;
    nx = m_cnt + 16'd1; up = 1'b1; tl = 1'b0; wrap = 1'b0; dn2 = m_dn;
    if (m_mode == 2'd0) begin
      wrap = (m_cnt == 16'hFFFF); dn2 = 1'b0;
    end else if (!m_dn) begin
      if (m_cnt >= top_of(m_mode)) begin nx = m_cnt - 16'd1; up = 1'b0; dn2 = 1'b1; end
      else tl = (nx == top_of(m_mode));
    end else if (m_cnt == 16'd0) begin
      nx = 16'd1; dn2 = 1'b0;
    end else begin
      nx = m_cnt - 16'd1; up = 1'b0; wrap = (nx == 16'd0);
    end
    for (int k = 0; k < 2; k++) begin
      if (nx == m_act[k]) begin
        m_flag[1+k] = 1'b1;
        m_pin[k] = (m_mode != 2'd0) ? !up : !m_pin[k];
      end
      if (tl) m_act[k] = m_buf[k];
    end
    if (wrap) m_flag[0] = 1'b1;
    m_cnt = nx; m_dn = dn2;
  endfunction

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    if (a == 4'd0) begin m_mode = d[1:0]; if (m_mode == 2'd0) m_dn = 1'b0; end
    if (a == 4'd2) m_flag = m_flag & ~d[3:0];
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wr16(input logic [3:0] lo, input logic [15:0] v);
    bus_write(lo + 4'd1, v[15:8]);
    bus_write(lo, v[7:0]);
    if (lo == 4'd4) m_cnt = v;
    for (int k = 0; k < 2; k++)
      if (lo == 4'(6 + 2 * k)) begin m_buf[k] = v; if (m_mode == 2'd0) m_act[k] = v; end
  endtask

  task automatic rd16(input logic [3:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    bus_read(lo, l);
    bus_read(lo + 4'd1, h);
    v = {h, l};
  endtask

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cnt_en = 1'b1; model_step();
    end
    @(negedge clk); cnt_en = 1'b0;
  endtask

  // steps one strobe at a time and compares both pins after each step
  task automatic strobe_chk(input int n, input string req);
    int bad = 0;
    logic [1:0] first_act = '0, first_exp = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0 && {cmp_out_b, cmp_out_a} !== m_pin) begin
        if (bad == 0) begin first_act = {cmp_out_b, cmp_out_a}; first_exp = m_pin; end
        bad++;
      end
      cnt_en = 1'b1; model_step();
    end
    @(negedge clk); cnt_en = 1'b0;
    if (bad == 0) begin first_act = {cmp_out_b, cmp_out_a}; first_exp = m_pin; end
    chk(req, 32'(first_act), 32'(first_exp));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] v, v0;
    logic [7:0]  b;
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 rdata", 32'(bus_rdata), 0);
    chk("R1 pins", 32'({cmp_out_b, cmp_out_a}), 0);
    chk("R1 irq", 32'(irq), 0);
    rd16(4'd4, v);  chk("R1 count", 32'(v), 0);
    bus_read(4'd2, b); chk("R1 flags", 32'(b), 0);
    rd16(4'd6, v);  chk("R1 compare A", 32'(v), 0);

    // R2: random runs of strobes in normal mode
    for (int t = 0; t < 6; t++) begin
      if (t == 3) wr16(4'd4, 16'($urandom_range(16'h8000, 16'hF000)));
      strobe($urandom_range(1, 60));
      rd16(4'd4, v); chk("R2 count after strobes", 32'(v), 32'(m_cnt));
    end
    repeat (10) @(negedge clk);
    rd16(4'd4, v); chk("R2 count holds without strobe", 32'(v), 32'(m_cnt));

    // R2: wrap sets overflow
    bus_write(4'd2, 8'h0F);
    wr16(4'd4, 16'hFFFE);
    strobe(3);
    rd16(4'd4, v); chk("R2 wrap count", 32'(v), 32'h1);
    bus_read(4'd2, b); chk("R2 overflow flag", 32'(b[0]), 1);
    chk("R2 flag register", 32'(b), 32'(m_flag));

    // R6: write-one-to-clear, bit by bit
    bus_write(4'd2, 8'h01);
    bus_read(4'd2, b); chk("R6 clear only bit 0", 32'(b), 32'(m_flag));
    bus_write(4'd2, 8'h0F);
    bus_read(4'd2, b); chk("R6 clear all", 32'(b), 0);

    // R3: matches in normal mode, random compare values
    for (int t = 0; t < 3; t++) begin
      v0 = 16'($urandom_range(16'h0100, 16'h7000));
      wr16(4'd6, v0 + 16'd7);
      wr16(4'd8, v0 + 16'd20);
      wr16(4'd4, v0);
      strobe(32);
      bus_read(4'd2, b); chk("R3 compare flags", 32'(b[2:1]), 32'(m_flag[2:1]));
      chk("R3 pins toggled", 32'({cmp_out_b, cmp_out_a}), 32'(m_pin));
      bus_write(4'd2, 8'h0F);
    end

    // R5: 16-bit access through the temporary byte
    rd16(4'd6, v); chk("R5 compare A read back", 32'(v), 32'(m_buf[0]));
    rd16(4'd8, v); chk("R5 compare B read back", 32'(v), 32'(m_buf[1]));
    wr16(4'd4, 16'h12F0);
    bus_read(4'd4, b); chk("R5 low byte", 32'(b), 32'h12F0 & 32'hFF);
    strobe(300);
    bus_read(4'd5, b); chk("R5 high byte latched on low read", 32'(b), 32'h12);

    // R7: interrupt lines follow flags through the mask
    bus_write(4'd2, 8'h0F);
    bus_write(4'd3, 8'h02);
    wr16(4'd6, 16'h2000);
    wr16(4'd4, 16'h1FFF);
    strobe(1);
    @(negedge clk);
    chk("R7 irq compare A", 32'(irq), 32'(m_flag & 4'h2));
    bus_write(4'd3, 8'h00);
    @(negedge clk);
    chk("R7 irq masked", 32'(irq), 0);

    // R4: capture, rising edge selected
    bus_write(4'd2, 8'h0F);
    bus_write(4'd1, 8'h01);
    wr16(4'd4, 16'h4321);
    @(negedge clk); cap_in = 1'b1;
    repeat (5) @(negedge clk);
    bus_read(4'd2, b); chk("R4 capture flag on rising", 32'(b[3]), 1);
    rd16(4'd10, v); chk("R4 captured count", 32'(v), 32'h4321);
    bus_write(4'd2, 8'h08);
    wr16(4'd4, 16'h1111);
    @(negedge clk); cap_in = 1'b0;
    repeat (5) @(negedge clk);
    bus_read(4'd2, b); chk("R4 falling edge ignored (flag)", 32'(b[3]), 0);
    rd16(4'd10, v); chk("R4 falling edge ignored (value)", 32'(v), 32'h4321);
    bus_write(4'd1, 8'h00);
    @(negedge clk); cap_in = 1'b1;
    repeat (5) @(negedge clk);
    rd16(4'd10, v); chk("R4 rising edge ignored when falling selected", 32'(v), 32'h4321);
    @(negedge clk); cap_in = 1'b0;
    repeat (5) @(negedge clk);
    rd16(4'd10, v); chk("R4 falling edge captures", 32'(v), 32'h1111);
    bus_write(4'd2, 8'h0F);

    // R8/R9: 8-bit phase-correct PWM
    wr16(4'd6, 16'h0040);
    wr16(4'd8, 16'h00C0);
    wr16(4'd4, 16'h0000);
    bus_write(4'd0, 8'h01);
    strobe_chk(600, "R9 PWM pins 8-bit");
    bus_read(4'd2, b); chk("R8 overflow at bottom", 32'(b), 32'(m_flag));
    rd16(4'd4, v); chk("R8 count in PWM", 32'(v), 32'(m_cnt));

    // R10: buffered compare values
    wr16(4'd6, 16'h0080);
    rd16(4'd6, v); chk("R10 buffer reads back", 32'(v), 32'h0080);
    wr16(4'd8, 16'h0010);
    strobe_chk(700, "R10 PWM pins after buffered update");

    // R8: top for each resolution
    for (int r = 1; r <= 3; r++) begin
      bus_write(4'd0, 8'h00);
      wr16(4'd4, 16'h0000);
      bus_write(4'd0, 8'(r));
      strobe(int'(top_of(2'(r))) + 5);
      rd16(4'd4, v); chk("R8 count past top", 32'(v), 32'(top_of(2'(r)) - 16'd5));
    end
    bus_write(4'd0, 8'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule